// File: doc/BRIEF.md
# Nonvolatile Byte Array Program/Erase Sequencer

This block models a small nonvolatile byte array and one configuration byte, along with the digital sequencing that guards changes to them. A processor reaches it over a simple bus: address, write data, write strobe and combinational read data. A control register has three bits: a latch bit, a high-voltage enable bit and an erase bit. A change only takes effect after a strict unlock order. First the latch bit is set. Then one target byte is written, and the address and data of that write are held. Then the enable bit is set. Clearing the enable bit commits the held operation. An erase makes the target byte all ones. A program can only clear bits, so it ANDs the held data into the byte.

Per-section protect inputs stop the sequence from being armed for guarded sections and for the configuration byte. Bit 0 of the configuration byte makes the array visible on the bus. A pump clock source request passes through a register to a select output. Charge-pump and cell physics are not modelled.

Address map with the default parameters:
- 0x00–0x1F: the array, in four sections of eight bytes. The section number is address bits [4:3].
- 0x3E: the control register.
- 0x3F: the configuration byte.

Top module: `nvm_seq`

## Requirements
- R1: After reset every array byte reads 0xFF and the configuration byte reads 0x01. The control register reads 0x00, and hv_en and busy are 0.
- R2: The control register at 0x3E reads back the state that took effect: bit 0 is enable, bit 1 is latch and bit 2 is erase. The erase bit can be written at any time except while enable is active.
- R3: While latch is 0, writes to array bytes and to the configuration byte are ignored, and reads return the stored values.
- R4: hv_en asserts only after three writes in this order: a control write with latch=1 and enable=0, then a write to a valid array or configuration target, then a control write with latch=1 and enable=1. An enable write with no held target leaves enable at 0.
- R5: A single control write with latch=1 and enable=1 made while latch is 0 leaves both latch and enable at 0.
- R6: Only the first target write after latch is set is held. Later target writes in the same sequence have no effect.
- R7: A control write that clears enable while it is active commits the held operation on the next clock edge. With erase=1 the target becomes 0xFF; with erase=0 the target becomes its old value ANDed with the held data.
- R8: busy is high from the cycle enable asserts through the commit cycle. An array read while busy is high returns 0xFF.
- R9: When prot_in[s] is 1, a write to array section s (address bits [4:3]) is not held. When prot_in[4] is 1, a write to the configuration byte is not held. In either case the sequence cannot arm.
- R10: When bit 0 of the configuration byte is 0, array reads return 0x00 and array writes are not held as targets.
- R11: pump_sel equals the pump_src input one clock edge later. A value of 0 selects the bus clock and 1 selects the internal oscillator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 8 | Bus address |
| wdata | input | 8 | Bus write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_data | output | 8 | Combinational read data for addr |
| prot_in | input | 5 | Protect bits: [3:0] array sections, [4] configuration byte |
| pump_src | input | 1 | Pump clock source request (0 bus clock, 1 oscillator) |
| pump_sel | output | 1 | Registered pump clock select |
| hv_en | output | 1 | Programming voltage enable |
| busy | output | 1 | Operation in progress |

## Verification
The bench runs the unlock order with several kinds of input:
- Correct orderings, both program and erase.
- A combined latch-and-enable write, which separates R5 from a legal arm.
- An enable write with no held target.
- A second target write, which can only be told apart from the first by its data.

The program data 0x0F applied over 0xA5 tells AND apart from overwrite, since overwrite would give 0x0F and AND gives 0x05. The protect and visibility cases repeat the same sequence on a guarded or hidden target, where hv_en must stay low. Programming the configuration byte to 0x00 and then erasing it back to 0xFF hides and then reveals the array.

// File: rtl/nvm_pkg.sv
// Shared constants for the nonvolatile array sequencer.
// Assumes byte-wide data and a three-bit control register.
package nvm_pkg;
    localparam int DATA_W   = 8;
    localparam int CTRL_GO  = 0;   // high-voltage enable bit
    localparam int CTRL_LAT = 1;   // latch bit
    localparam int CTRL_ERS = 2;   // erase select bit
    typedef logic [DATA_W-1:0] byte_t;
    localparam byte_t ERASED = 8'hFF;
endpackage

// File: rtl/nvm_ctrl.sv
// Sequencing logic: latch, enable and erase bits, target capture and commit issue.
// Assumes the caller presents a write to the control register and a target write
// as separate cycles. wr_target is already qualified for validity, protection and
// visibility.
module nvm_ctrl #(
    parameter int IDX_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_ctrl,
    input  logic                 wr_target,
    input  logic                 tgt_cfg,
    input  logic [IDX_W-1:0]     tgt_idx,
    input  nvm_pkg::byte_t       wdata,
    output logic                 go_q,
    output logic                 latch_q,
    output logic                 erase_q,
    output logic                 commit_q,
    output logic                 commit_erase,
    output logic                 commit_cfg,
    output logic [IDX_W-1:0]     commit_idx,
    output nvm_pkg::byte_t       commit_data
);
    import nvm_pkg::*;

    logic req_go, req_lat, req_ers;
    logic cap_valid;

    assign req_go  = wdata[CTRL_GO];
    assign req_lat = wdata[CTRL_LAT];
    assign req_ers = wdata[CTRL_ERS];

    // Control bits, unlock order and commit request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_q         <= 1'b0;
            latch_q      <= 1'b0;
            erase_q      <= 1'b0;
            commit_q     <= 1'b0;
            commit_erase <= 1'b0;
            cap_valid    <= 1'b0;
        end else begin
            commit_q <= 1'b0;
            if (wr_ctrl) begin
                if (go_q) begin
                    if (!req_go) begin
                        go_q         <= 1'b0;
                        latch_q      <= req_lat;
                        commit_q     <= 1'b1;
                        commit_erase <= erase_q;
                        cap_valid    <= 1'b0;
                        erase_q      <= req_ers;
                    end
                end else begin
                    erase_q <= req_ers;
                    if (req_go && req_lat && !latch_q) begin
                        latch_q <= 1'b0;
                    end else begin
                        latch_q <= req_lat;
                    end
                    if (req_go && req_lat && latch_q && cap_valid) begin
                        go_q <= 1'b1;
                    end
                    if (!req_lat) begin
                        cap_valid <= 1'b0;
                    end
                end
            end else if (wr_target && latch_q && !cap_valid && !go_q) begin
                cap_valid <= 1'b1;
            end
        end
    end

    // Held target address and data; no reset needed.
    always_ff @(posedge clk) begin
        if (!wr_ctrl && wr_target && latch_q && !cap_valid && !go_q) begin
            commit_cfg  <= tgt_cfg;
            commit_idx  <= tgt_idx;
            commit_data <= wdata;
        end
    end
endmodule

// File: rtl/nvm_store.sv
// Array and configuration byte storage with program (AND) and erase (all ones)
// update. Assumes at most one commit per cycle, driven by the sequencer.
module nvm_store #(
    parameter int            DEPTH    = 32,
    parameter nvm_pkg::byte_t CFG_INIT = 8'h01,
    localparam int           IDX_W    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit_q,
    input  logic             commit_erase,
    input  logic             commit_cfg,
    input  logic [IDX_W-1:0] commit_idx,
    input  nvm_pkg::byte_t   commit_data,
    input  logic [IDX_W-1:0] rd_idx,
    output nvm_pkg::byte_t   rd_byte,
    output nvm_pkg::byte_t   cfg_byte
);
    import nvm_pkg::*;

    byte_t mem [DEPTH];
    byte_t new_val;
    byte_t old_val;

    // Value written by a commit: erase forces ones, program clears bits.
    always_comb begin
        old_val = commit_cfg ? cfg_byte : mem[commit_idx];
        new_val = commit_erase ? ERASED : (old_val & commit_data);
    end

    // Array storage, reset to the erased state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
        end else if (commit_q && !commit_cfg) begin
            mem[commit_idx] <= new_val;
        end
    end

    // Configuration byte storage.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cfg_byte <= CFG_INIT;
        else if (commit_q && commit_cfg) cfg_byte <= new_val;
    end

    assign rd_byte = mem[rd_idx];
endmodule

// File: rtl/nvm_seq.sv
// Top level: address decode, target qualification, read mux, pump select.
// Assumes the array sits at address 0 and has a power-of-two depth that divides
// evenly into SECTIONS equal sections.
module nvm_seq #(
    parameter int            ADDR_W    = 8,
    parameter int            DEPTH     = 32,
    parameter int            SECTIONS  = 4,
    parameter logic [7:0]    CTRL_ADDR = 8'h3E,
    parameter logic [7:0]    CFG_ADDR  = 8'h3F,
    parameter logic [7:0]    CFG_INIT  = 8'h01
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [7:0]           wdata,
    input  logic                 wr_en,
    output logic [7:0]           rd_data,
    input  logic [SECTIONS:0]    prot_in,
    input  logic                 pump_src,
    output logic                 pump_sel,
    output logic                 hv_en,
    output logic                 busy
);
    import nvm_pkg::*;

    localparam int IDX_W = $clog2(DEPTH);
    localparam int SEC_W = (SECTIONS > 1) ? $clog2(SECTIONS) : 1;
    localparam logic [ADDR_W-1:0] DEPTH_A = ADDR_W'(DEPTH);

    logic             sel_ctrl, sel_cfg, sel_arr;
    logic             vis, sec_prot, wr_target;
    logic [IDX_W-1:0] idx;
    logic             ctrl_go, ctrl_latch, ctrl_erase;
    logic             commit_q, commit_erase, commit_cfg;
    logic [IDX_W-1:0] commit_idx;
    byte_t            commit_data, arr_byte, cfg_byte;

    assign idx      = addr[IDX_W-1:0];
    assign sel_ctrl = (addr == ADDR_W'(CTRL_ADDR));
    assign sel_cfg  = (addr == ADDR_W'(CFG_ADDR));
    assign sel_arr  = (addr < DEPTH_A);
    assign vis      = cfg_byte[0];

    // Section protect lookup; a single section uses bit 0 only.
    generate
        if (SECTIONS > 1) begin : g_multi
            assign sec_prot = prot_in[idx[IDX_W-1 -: SEC_W]];
        end else begin : g_single
            assign sec_prot = prot_in[0];
        end
    endgenerate

    // A write is a valid target when its byte is visible and unprotected.
    assign wr_target = wr_en && ((sel_arr && vis && !sec_prot) ||
                                 (sel_cfg && !prot_in[SECTIONS]));

    nvm_ctrl #(.IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_ctrl(wr_en && sel_ctrl), .wr_target(wr_target),
        .tgt_cfg(sel_cfg), .tgt_idx(idx), .wdata(wdata),
        .go_q(ctrl_go), .latch_q(ctrl_latch), .erase_q(ctrl_erase),
        .commit_q(commit_q), .commit_erase(commit_erase), .commit_cfg(commit_cfg),
        .commit_idx(commit_idx), .commit_data(commit_data)
    );

    nvm_store #(.DEPTH(DEPTH), .CFG_INIT(CFG_INIT)) u_store (
        .clk(clk), .rst_n(rst_n),
        .commit_q(commit_q), .commit_erase(commit_erase), .commit_cfg(commit_cfg),
        .commit_idx(commit_idx), .commit_data(commit_data),
        .rd_idx(idx), .rd_byte(arr_byte), .cfg_byte(cfg_byte)
    );

    assign hv_en = ctrl_go;
    assign busy  = ctrl_go || commit_q;

    // Read mux: control, configuration, then the array gated by visibility and busy.
    always_comb begin
        rd_data = 8'h00;
        if (sel_ctrl) begin
            rd_data[CTRL_GO]  = ctrl_go;
            rd_data[CTRL_LAT] = ctrl_latch;
            rd_data[CTRL_ERS] = ctrl_erase;
        end else if (sel_cfg) begin
            rd_data = cfg_byte;
        end else if (sel_arr && vis) begin
            rd_data = busy ? ERASED : arr_byte;
        end
    end

    // Pump clock select register.
    always_ff @(posedge clk) begin
        if (!rst_n) pump_sel <= 1'b0;
        else        pump_sel <= pump_src;
    end
endmodule

// File: rtl/nvm_seq_checker.sv
// Temporal checks on the sequencer, bound to nvm_seq.
module nvm_seq_checker #(
    parameter int         ADDR_W    = 8,
    parameter int         DEPTH     = 32,
    parameter logic [7:0] CTRL_ADDR = 8'h3E
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wdata,
    input logic              wr_en,
    input logic [7:0]        rd_data,
    input logic              pump_src,
    input logic              pump_sel,
    input logic              hv_en,
    input logic              busy,
    input logic              latch_q,
    input logic [7:0]        cfg_byte
);
    logic ctrl_hit;
    assign ctrl_hit = wr_en && (addr == ADDR_W'(CTRL_ADDR)) && (wdata[1:0] == 2'b11);

    assert_arm_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hv_en) |-> $past(ctrl_hit && latch_q));

    assert_combined_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_hit && !latch_q && !hv_en) |=> (!latch_q && !hv_en));

    assert_busy_cover_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hv_en |-> busy);

    assert_busy_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (addr < ADDR_W'(DEPTH)) && cfg_byte[0]) |-> (rd_data == 8'hFF));

    assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_q && !busy) |=> $stable(cfg_byte));

    assert_pump_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pump_sel == $past(pump_src)));
endmodule

bind nvm_seq nvm_seq_checker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CTRL_ADDR(CTRL_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_data(rd_data), .pump_src(pump_src), .pump_sel(pump_sel),
    .hv_en(hv_en), .busy(busy), .latch_q(ctrl_latch), .cfg_byte(cfg_byte)
);

// File: tb/nvm_seq_bench.sv
// Directed bench for nvm_seq: one task per scenario, each checking its results.
module nvm_seq_bench;
    localparam logic [7:0] CTRL = 8'h3E;
    localparam logic [7:0] CFG  = 8'h3F;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic       wr_en = 1'b0;
    logic [7:0] rd_data;
    logic [4:0] prot_in = 5'b0;
    logic       pump_src = 1'b0;
    logic       pump_sel, hv_en, busy;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    nvm_seq u_nvm_seq (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_data(rd_data), .prot_in(prot_in), .pump_src(pump_src),
        .pump_sel(pump_sel), .hv_en(hv_en), .busy(busy)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One write cycle; returns at the following falling edge.
    task automatic wr(logic [7:0] a, logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] d);
        addr = a;
        #1 d = rd_data;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(CTRL, d); check("R1 ctrl", d, 8'h00);
        rd(CFG, d);  check("R1 cfg", d, 8'h01);
        rd(8'h00, d); check("R1 arr0", d, 8'hFF);
        rd(8'h1F, d); check("R1 arr31", d, 8'hFF);
        check("R1 hv_en", {7'b0, hv_en}, 8'h00);
        check("R1 busy", {7'b0, busy}, 8'h00);
    endtask

    task automatic t_readonly();
        logic [7:0] d;
        wr(8'h05, 8'h12); rd(8'h05, d); check("R3 arr write ignored", d, 8'hFF);
        wr(CFG, 8'h00);   rd(CFG, d);   check("R3 cfg write ignored", d, 8'h01);
    endtask

    task automatic t_combined();
        logic [7:0] d;
        wr(CTRL, 8'h03); rd(CTRL, d); check("R5 both cleared", d, 8'h00);
        check("R5 hv_en low", {7'b0, hv_en}, 8'h00);
        wr(CTRL, 8'h06); rd(CTRL, d); check("R2 erase+latch readback", d, 8'h06);
        wr(CTRL, 8'h00);
    endtask

    task automatic t_no_target();
        logic [7:0] d;
        wr(CTRL, 8'h02); wr(CTRL, 8'h03); rd(CTRL, d);
        check("R4 enable without target", d, 8'h02);
        wr(CTRL, 8'h00);
    endtask

    // Full sequence on one target; checks arm, busy window and result.
    task automatic t_op(string req, logic [7:0] a, logic [7:0] d1, logic ers,
                        logic [7:0] exp);
        logic [7:0] d;
        wr(CTRL, {5'b0, ers, 2'b10});
        wr(a, d1);
        wr(a, 8'h00);                               // second target write, R6
        wr(CTRL, {5'b0, ers, 2'b11});
        check({req, " R4 hv_en armed"}, {7'b0, hv_en}, 8'h01);
        rd(CTRL, d); check({req, " R2 ctrl readback"}, d, {5'b0, ers, 2'b11});
        if (a != CFG) begin
            rd(a, d); check({req, " R8 read while busy"}, d, 8'hFF);
        end
        wr(CTRL, {5'b0, ers, 2'b10});
        check({req, " R8 busy in commit cycle"}, {7'b0, busy}, 8'h01);
        @(negedge clk);
        check({req, " R8 busy released"}, {7'b0, busy}, 8'h00);
        rd(a, d); check({req, " R7 R6 result"}, d, exp);
        wr(CTRL, 8'h00);
    endtask

    task automatic t_protect();
        logic [7:0] d;
        prot_in = 5'b00001;
        wr(CTRL, 8'h02); wr(8'h05, 8'h00); wr(CTRL, 8'h03);
        check("R9 section guarded", {7'b0, hv_en}, 8'h00);
        wr(CTRL, 8'h00); rd(8'h05, d); check("R9 data kept", d, 8'hA5);
        prot_in = 5'b10000;
        wr(CTRL, 8'h02); wr(CFG, 8'h00); wr(CTRL, 8'h03);
        check("R9 cfg guarded", {7'b0, hv_en}, 8'h00);
        wr(CTRL, 8'h00);
        prot_in = 5'b0;
    endtask

    task automatic t_visibility();
        logic [7:0] d;
        t_op("R10 cfg program", CFG, 8'hFE, 1'b0, 8'h00);
        rd(8'h05, d); check("R10 hidden read", d, 8'h00);
        wr(CTRL, 8'h02); wr(8'h06, 8'h00); wr(CTRL, 8'h03);
        check("R10 hidden write not held", {7'b0, hv_en}, 8'h00);
        wr(CTRL, 8'h00);
        t_op("R7 cfg erase", CFG, 8'h00, 1'b1, 8'hFF);
        rd(8'h05, d); check("R10 visible again", d, 8'hA5);
        rd(8'h06, d); check("R10 untouched byte", d, 8'hFF);
    endtask

    task automatic t_pump();
        pump_src = 1'b1; @(negedge clk);
        check("R11 pump osc", {7'b0, pump_sel}, 8'h01);
        pump_src = 1'b0; @(negedge clk);
        check("R11 pump bus clock", {7'b0, pump_sel}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readonly();
        t_combined();
        t_no_target();
        t_op("program", 8'h05, 8'hA5, 1'b0, 8'hA5);
        t_op("and", 8'h05, 8'h0F, 1'b0, 8'h05);
        t_op("erase", 8'h05, 8'h00, 1'b1, 8'hFF);
        t_op("reprogram", 8'h05, 8'hA5, 1'b0, 8'hA5);
        t_protect();
        t_visibility();
        t_pump();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule